// File: doc/BRIEF.md
# Register Window Spill/Fill Controller

This block keeps the bookkeeping for a windowed integer register file: the current window pointer and four window counts (windows free to save into, windows holding restorable frames, clean windows, and windows that belong to another context). It does not store registers. For each save, restore or flush-windows request it decides whether the operation can go ahead. If it can, it updates the counters. If it cannot, it raises a spill, fill or clean-window trap.

A spill or fill trap comes in two variants, and the other-window count picks between them. When that count is nonzero, the trap is the "other" variant and its 3-bit handler selector comes from the upper half of the 6-bit window-state input. When the count is zero, the trap is the "normal" variant and the selector comes from the lower half. Each counter also has its own write enable, so the surrounding core can load the counters directly, for example after a trap handler has moved frames.

All outputs are registered. A request presented in one cycle produces its trap or completion pulse in the next cycle, and the counters show their new values in that same cycle.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the counters read cwp=0, cansave=NWIN-2, canrestore=0, cleanwin=NWIN-2 and otherwin=0. Neither trap_valid nor op_done is asserted.
- R2: A save with cansave nonzero and cleanwin different from canrestore completes. cwp and canrestore each go up by one, cansave goes down by one, and op_done pulses.
- R3: A save with cansave equal to zero raises a spill trap and advances cwp by two modulo NWIN. This check takes priority over the clean-window check, and the other counters are left unchanged.
- R4: A save with cansave nonzero where (cleanwin - canrestore) mod NWIN is zero raises a clean-window trap (kind 5, selector 0) and leaves all counters unchanged.
- R5: A restore with canrestore equal to zero raises a fill trap and leaves all counters unchanged.
- R6: A restore with canrestore nonzero completes. cwp and canrestore each go down by one, cansave goes up by one, and op_done pulses.
- R7: A flush-windows request raises a spill trap when NWIN-2-cansave is zero and otherwise pulses op_done. In both cases it leaves the counters unchanged.
- R8: When otherwin is nonzero, a spill or fill trap is the "other" variant with trap_sel = wstate_in[5:3]. When otherwin is zero, it is the "normal" variant with trap_sel = wstate_in[2:0]. The trap_kind codes are: 0 none, 1 spill normal, 2 spill other, 3 fill normal, 4 fill other, 5 clean.
- R9: op_code is encoded 0 idle, 1 save, 2 restore, 3 flush. trap_valid and op_done are one-cycle pulses in the cycle after the request, and they are never asserted together. An idle code produces neither.
- R10: Bit i of wr_en loads counter i from wr_data[3i+2:3i] on the next edge. The bit order is cwp=0, cansave=1, canrestore=2, cleanwin=3, otherwin=4. A write wins over an update of the same counter by a request in the same cycle.
- R11: cwp wraps modulo NWIN in both directions: save from 7 gives 0, restore from 0 gives 7, and a spill from 7 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 2 | Request: 0 idle, 1 save, 2 restore, 3 flush |
| wstate_in | input | 6 | Window-state register: [5:3] other handler, [2:0] normal handler |
| wr_en | input | 5 | Per-counter write enables |
| wr_data | input | 15 | Packed write data, three bits per counter |
| cwp | output | 3 | Current window pointer |
| cansave | output | 3 | Windows free for save |
| canrestore | output | 3 | Windows available for restore |
| cleanwin | output | 3 | Clean window count |
| otherwin | output | 3 | Other-context window count |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_kind | output | 3 | Encoded trap type |
| trap_sel | output | 3 | Handler selector from the window-state register |
| op_done | output | 1 | One-cycle pulse for a request completed without a trap |

## Verification
Saves are tried with a free window, with no free window, and with free windows but none clean. This separates the completion path, the spill path and the clean-window path, including the case where both trap conditions hold and spill must win. Restores and flushes are each tried on both sides of their test. Every spill and fill is run with otherwin both zero and nonzero, using a window-state value whose two halves differ, so a swapped selector or variant is visible. Pointer values at 0 and 7 expose wrap errors, and a write presented in the same cycle as a save shows whether writes take priority.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_SAVE    = 2'd1,
    OP_RESTORE = 2'd2,
    OP_FLUSH   = 2'd3
  } win_op_e;

  typedef enum logic [2:0] {
    TK_NONE      = 3'd0,
    TK_SPILL_NRM = 3'd1,
    TK_SPILL_OTH = 3'd2,
    TK_FILL_NRM  = 3'd3,
    TK_FILL_OTH  = 3'd4,
    TK_CLEAN     = 3'd5
  } trap_kind_e;

  localparam int NCNT       = 5;
  localparam int IDX_CWP    = 0;
  localparam int IDX_CSAVE  = 1;
  localparam int IDX_CREST  = 2;
  localparam int IDX_CLEAN  = 3;
  localparam int IDX_OTHER  = 4;
  localparam int SEL_W      = 3;
  localparam int WSTATE_W   = 2 * SEL_W;

  // Step a counter value by d (may be negative), result kept in [0, n).
  function automatic int wrap_step(input int v, input int d, input int n);
    int r;
    r = (v + d) % n;
    if (r < 0) r = r + n;
    return r;
  endfunction

  // Value each counter takes at reset.
  function automatic int reset_of(input int idx, input int n);
    int r;
    case (idx)
      IDX_CSAVE: r = n - 2;
      IDX_CLEAN: r = n - 2;
      default:   r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/regwin_cnt.sv
module regwin_cnt #(
  parameter int CNT_W   = 3,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             upd_en,
  input  logic [CNT_W-1:0] upd_val,
  output logic [CNT_W-1:0] q
);

  localparam logic [CNT_W-1:0] RST_Q = CNT_W'(RST_VAL);

  always_ff @(posedge clk) begin
    if (rst)          q <= RST_Q;
    else if (wr_en)   q <= wr_data;
    else if (upd_en)  q <= upd_val;
  end

  // R10: a direct write lands on the next edge, whatever the request did
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> q == $past(wr_data));

  // Without write or update the count holds
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !upd_en) |=> $stable(q));

endmodule

// File: rtl/regwin_decide.sv
module regwin_decide
  import regwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CNT_W = 3
) (
  input  win_op_e                     op,
  input  logic [CNT_W-1:0]            cnt [NCNT],
  input  logic [WSTATE_W-1:0]         wstate,
  output trap_kind_e                  kind,
  output logic [SEL_W-1:0]            sel,
  output logic                        done,
  output logic [NCNT-1:0]             upd_en,
  output logic [CNT_W-1:0]            upd_val [NCNT]
);

  logic              other_ctx;
  logic [SEL_W-1:0]  handler;
  logic              clean_short;
  logic              flush_full;
  int                cwp_i, cs_i, cr_i;

  assign cwp_i       = int'(cnt[IDX_CWP]);
  assign cs_i        = int'(cnt[IDX_CSAVE]);
  assign cr_i        = int'(cnt[IDX_CREST]);
  assign other_ctx   = (cnt[IDX_OTHER] != '0);
  assign handler     = other_ctx ? wstate[WSTATE_W-1:SEL_W] : wstate[SEL_W-1:0];
  assign clean_short = (wrap_step(int'(cnt[IDX_CLEAN]), -cr_i, NWIN) == 0);
  assign flush_full  = ((NWIN - 2 - cs_i) == 0);

  always_comb begin
    kind   = TK_NONE;
    sel    = '0;
    done   = 1'b0;
    upd_en = '0;
    for (int i = 0; i < NCNT; i++) upd_val[i] = cnt[i];

    unique case (op)
      OP_SAVE: begin
        if (cnt[IDX_CSAVE] == '0) begin
          kind = other_ctx ? TK_SPILL_OTH : TK_SPILL_NRM;
          sel  = handler;
          upd_en[IDX_CWP]  = 1'b1;
          upd_val[IDX_CWP] = CNT_W'(wrap_step(cwp_i, 2, NWIN));
        end else if (clean_short) begin
          kind = TK_CLEAN;
        end else begin
          done = 1'b1;
          upd_en[IDX_CWP]    = 1'b1;
          upd_en[IDX_CSAVE]  = 1'b1;
          upd_en[IDX_CREST]  = 1'b1;
          upd_val[IDX_CWP]   = CNT_W'(wrap_step(cwp_i, 1, NWIN));
          upd_val[IDX_CSAVE] = CNT_W'(wrap_step(cs_i, -1, NWIN));
          upd_val[IDX_CREST] = CNT_W'(wrap_step(cr_i, 1, NWIN));
        end
      end
      OP_RESTORE: begin
        if (cnt[IDX_CREST] == '0) begin
          kind = other_ctx ? TK_FILL_OTH : TK_FILL_NRM;
          sel  = handler;
        end else begin
          done = 1'b1;
          upd_en[IDX_CWP]    = 1'b1;
          upd_en[IDX_CSAVE]  = 1'b1;
          upd_en[IDX_CREST]  = 1'b1;
          upd_val[IDX_CWP]   = CNT_W'(wrap_step(cwp_i, -1, NWIN));
          upd_val[IDX_CSAVE] = CNT_W'(wrap_step(cs_i, 1, NWIN));
          upd_val[IDX_CREST] = CNT_W'(wrap_step(cr_i, -1, NWIN));
        end
      end
      OP_FLUSH: begin
        if (flush_full) begin
          kind = other_ctx ? TK_SPILL_OTH : TK_SPILL_NRM;
          sel  = handler;
        end else begin
          done = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // R9: a decision is never both a trap and a completion
  always_comb begin
    a_excl_r9: assert (!(done && (kind != TK_NONE)));
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CNT_W = $clog2(NWIN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              op_code,
  input  logic [5:0]              wstate_in,
  input  logic [4:0]              wr_en,
  input  logic [5*CNT_W-1:0]      wr_data,
  output logic [CNT_W-1:0]        cwp,
  output logic [CNT_W-1:0]        cansave,
  output logic [CNT_W-1:0]        canrestore,
  output logic [CNT_W-1:0]        cleanwin,
  output logic [CNT_W-1:0]        otherwin,
  output logic                    trap_valid,
  output logic [2:0]              trap_kind,
  output logic [2:0]              trap_sel,
  output logic                    op_done
);

  win_op_e           op;
  logic [CNT_W-1:0]  cnt_q   [NCNT];
  logic [CNT_W-1:0]  upd_val [NCNT];
  logic [NCNT-1:0]   upd_en;
  trap_kind_e        dec_kind;
  logic [SEL_W-1:0]  dec_sel;
  logic              dec_done;

  assign op = win_op_e'(op_code);

  regwin_decide #(.NWIN(NWIN), .CNT_W(CNT_W)) u_decide (
    .op      (op),
    .cnt     (cnt_q),
    .wstate  (wstate_in),
    .kind    (dec_kind),
    .sel     (dec_sel),
    .done    (dec_done),
    .upd_en  (upd_en),
    .upd_val (upd_val)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    regwin_cnt #(.CNT_W(CNT_W), .RST_VAL(reset_of(g, NWIN))) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en[g]),
      .wr_data (wr_data[g*CNT_W +: CNT_W]),
      .upd_en  (upd_en[g]),
      .upd_val (upd_val[g]),
      .q       (cnt_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_kind  <= TK_NONE;
      trap_sel   <= '0;
      op_done    <= 1'b0;
    end else begin
      trap_valid <= (dec_kind != TK_NONE);
      trap_kind  <= dec_kind;
      trap_sel   <= dec_sel;
      op_done    <= dec_done;
    end
  end

  assign cwp        = cnt_q[IDX_CWP];
  assign cansave    = cnt_q[IDX_CSAVE];
  assign canrestore = cnt_q[IDX_CREST];
  assign cleanwin   = cnt_q[IDX_CLEAN];
  assign otherwin   = cnt_q[IDX_OTHER];

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(trap_valid && op_done));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (op_code == 2'd0) |=> (!trap_valid && !op_done));

  p_spill_step_r3: assert property (@(posedge clk) disable iff (rst)
    (op_code == 2'd1 && cansave == '0 && wr_en == '0)
      |=> (trap_valid && cwp == CNT_W'(wrap_step(int'($past(cwp)), 2, NWIN))));

  p_fill_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (op_code == 2'd2 && canrestore == '0 && wr_en == '0)
      |=> (trap_valid && $stable(cwp) && $stable(cansave) && $stable(canrestore)));

  p_save_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (op_code == 2'd1 && cansave != '0 && cleanwin != canrestore && wr_en == '0)
      |=> (op_done && canrestore == CNT_W'(wrap_step(int'($past(canrestore)), 1, NWIN))));

  p_sel_other_r8: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && (trap_kind == TK_SPILL_OTH || trap_kind == TK_FILL_OTH))
      |-> trap_sel == $past(wstate_in[5:3]));

endmodule

// File: tb/regwin_ctrl_tb.sv
module regwin_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  op_code;
  logic [5:0]  wstate_in;
  logic [4:0]  wr_en;
  logic [14:0] wr_data;
  logic [2:0]  cwp, cansave, canrestore, cleanwin, otherwin;
  logic        trap_valid, op_done;
  logic [2:0]  trap_kind, trap_sel;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  regwin_ctrl dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .wstate_in(wstate_in),
    .wr_en(wr_en), .wr_data(wr_data), .cwp(cwp), .cansave(cansave),
    .canrestore(canrestore), .cleanwin(cleanwin), .otherwin(otherwin),
    .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_sel(trap_sel),
    .op_done(op_done)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic [2:0] cwp, cs, cr, cw, ow;
    logic [5:0] ws;
    logic [1:0] op;
    logic [2:0] ecwp, ecs, ecr, ecw, eow, kind, sel;
    logic       done;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    // R2 save completes
    '{4'd2, 3'd2,3'd4,3'd1,3'd6,3'd0, 6'o52, 2'd1, 3'd3,3'd3,3'd2,3'd6,3'd0, 3'd0,3'd0,1'b1},
    // R11 save wraps 7 -> 0
    '{4'd11,3'd7,3'd2,3'd3,3'd7,3'd0, 6'o52, 2'd1, 3'd0,3'd1,3'd4,3'd7,3'd0, 3'd0,3'd0,1'b1},
    // R3 spill normal, R8 selector low half
    '{4'd3, 3'd5,3'd0,3'd4,3'd6,3'd0, 6'o53, 2'd1, 3'd7,3'd0,3'd4,3'd6,3'd0, 3'd1,3'd3,1'b0},
    // R8 spill other, selector high half
    '{4'd8, 3'd5,3'd0,3'd3,3'd6,3'd2, 6'o53, 2'd1, 3'd7,3'd0,3'd3,3'd6,3'd2, 3'd2,3'd5,1'b0},
    // R11 spill wraps 7 -> 1
    '{4'd11,3'd7,3'd0,3'd2,3'd3,3'd1, 6'o61, 2'd1, 3'd1,3'd0,3'd2,3'd3,3'd1, 3'd2,3'd6,1'b0},
    // R3 spill beats clean check
    '{4'd3, 3'd1,3'd0,3'd5,3'd5,3'd0, 6'o02, 2'd1, 3'd3,3'd0,3'd5,3'd5,3'd0, 3'd1,3'd2,1'b0},
    // R4 clean-window trap
    '{4'd4, 3'd3,3'd2,3'd4,3'd4,3'd0, 6'o71, 2'd1, 3'd3,3'd2,3'd4,3'd4,3'd0, 3'd5,3'd0,1'b0},
    // R5 fill normal
    '{4'd5, 3'd4,3'd5,3'd0,3'd5,3'd0, 6'o27, 2'd2, 3'd4,3'd5,3'd0,3'd5,3'd0, 3'd3,3'd7,1'b0},
    // R8 fill other
    '{4'd8, 3'd4,3'd5,3'd0,3'd5,3'd1, 6'o27, 2'd2, 3'd4,3'd5,3'd0,3'd5,3'd1, 3'd4,3'd2,1'b0},
    // R6 restore completes
    '{4'd6, 3'd4,3'd2,3'd3,3'd6,3'd0, 6'o00, 2'd2, 3'd3,3'd3,3'd2,3'd6,3'd0, 3'd0,3'd0,1'b1},
    // R11 restore wraps 0 -> 7
    '{4'd11,3'd0,3'd1,3'd5,3'd6,3'd0, 6'o00, 2'd2, 3'd7,3'd2,3'd4,3'd6,3'd0, 3'd0,3'd0,1'b1},
    // R7 flush spill normal
    '{4'd7, 3'd2,3'd6,3'd0,3'd6,3'd0, 6'o14, 2'd3, 3'd2,3'd6,3'd0,3'd6,3'd0, 3'd1,3'd4,1'b0},
    // R7 flush spill other
    '{4'd7, 3'd2,3'd6,3'd1,3'd6,3'd3, 6'o14, 2'd3, 3'd2,3'd6,3'd1,3'd6,3'd3, 3'd2,3'd1,1'b0},
    // R7 flush completes
    '{4'd7, 3'd2,3'd3,3'd2,3'd6,3'd0, 6'o14, 2'd3, 3'd2,3'd3,3'd2,3'd6,3'd0, 3'd0,3'd0,1'b1},
    // R9 idle code does nothing
    '{4'd9, 3'd2,3'd3,3'd2,3'd6,3'd0, 6'o14, 2'd0, 3'd2,3'd3,3'd2,3'd6,3'd0, 3'd0,3'd0,1'b0}
  };

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input int req, input int c0, input int c1,
                             input int c2, input int c3, input int c4);
    check(cwp == 3'(c0), req, "cwp", cwp, c0);
    check(cansave == 3'(c1), req, "cansave", cansave, c1);
    check(canrestore == 3'(c2), req, "canrestore", canrestore, c2);
    check(cleanwin == 3'(c3), req, "cleanwin", cleanwin, c3);
    check(otherwin == 3'(c4), req, "otherwin", otherwin, c4);
  endtask

  task automatic load(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                      input logic [2:0] d, input logic [2:0] e);
    @(negedge clk);
    op_code = 2'd0;
    wr_en   = 5'h1f;
    wr_data = {e, d, c, b, a};
    @(negedge clk);
    wr_en   = 5'h00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; op_code = 2'd0; wstate_in = '0; wr_en = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_state(1, 0, 6, 0, 6, 0);
    check(!trap_valid && !op_done, 1, "pulses after reset", trap_valid, 0);

    for (int i = 0; i < NV; i++) begin
      load(VT[i].cwp, VT[i].cs, VT[i].cr, VT[i].cw, VT[i].ow);
      op_code   = VT[i].op;
      wstate_in = VT[i].ws;
      @(negedge clk);
      op_code = 2'd0;
      check_state(VT[i].rq, VT[i].ecwp, VT[i].ecs, VT[i].ecr, VT[i].ecw, VT[i].eow);
      check(trap_kind == VT[i].kind, VT[i].rq, "trap_kind", trap_kind, VT[i].kind);
      check(trap_valid == (VT[i].kind != 3'd0), VT[i].rq, "trap_valid", trap_valid,
            VT[i].kind != 3'd0);
      check(trap_sel == VT[i].sel, VT[i].rq, "trap_sel", trap_sel, VT[i].sel);
      check(op_done == VT[i].done, VT[i].rq, "op_done", op_done, VT[i].done);
    end

    // R9 pulse lasts one cycle: spill, then idle
    load(3'd0, 3'd0, 3'd3, 3'd6, 3'd0);
    op_code = 2'd1;
    @(negedge clk);
    op_code = 2'd0;
    check(trap_valid == 1'b1, 9, "trap pulse present", trap_valid, 1);
    @(negedge clk);
    check(trap_valid == 1'b0, 9, "trap pulse gone", trap_valid, 0);

    // R10 write to cwp overrides save update, other counters still move
    load(3'd2, 3'd4, 3'd1, 3'd6, 3'd0);
    op_code = 2'd1;
    wr_en   = 5'b00001;
    wr_data = {3'd0, 3'd0, 3'd0, 3'd0, 3'd5};
    @(negedge clk);
    op_code = 2'd0;
    wr_en   = '0;
    check_state(10, 5, 3, 2, 6, 0);
    check(op_done == 1'b1, 10, "done with write", op_done, 1);

    // R10 single write touches only its counter
    wr_en   = 5'b10000;
    wr_data = {3'd3, 3'd1, 3'd1, 3'd1, 3'd1};
    @(negedge clk);
    wr_en = '0;
    check_state(10, 5, 3, 2, 6, 3);

    // R1 reset again restores defaults
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_state(1, 0, 6, 0, 6, 0);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule